// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

A single-port, one-bit-wide RAM whose stored contents and read results can be distorted, under run-time control, by one classic functional memory fault at a time. It stands in for a real array while a March-style self-test engine is checked: the engine runs its element sequence against the model, and the bench or the engine's own compare logic shows whether the injected fault was caught.

The fault port picks a fault kind, a victim cell, an aggressor cell, a forced or blocked value (`flt_val_i`) and a trigger qualifier (`flt_trig_i`). Coupling faults that depend on aggressor edges compare the aggressor's stored bit with the bit being written to it, and change the victim in the same clock edge as that write. Faults that act on level (stuck-at, state coupling, bridging) are applied on the read path, so the stored bits stay as written. With the kind set to none, the block is an ideal RAM whose read data appears one cycle after the read.

Top module: `fault_ram`

## Requirements
- R1: After reset every cell holds 0 and `rdata_o` is 0.
- R2: With kind 0 (none), a read returns the last value written to that address on the clock edge after the read is issued; a cycle with `we_i` high leaves `rdata_o` unchanged.
- R3: Kind 1 (stuck-at): reads of the victim return `flt_val_i` whatever was written; other cells behave ideally.
- R4: Kind 2 (transition): a write to the victim that would move it from `~flt_val_i` to `flt_val_i` leaves it unchanged; the opposite transition works.
- R5: Kind 3 (inversion coupling): a write that moves the aggressor to the value `flt_trig_i` (1 = rising, 0 = falling) inverts the victim; a write with no change or the other edge leaves the victim alone.
- R6: Kind 4 (idempotent coupling): a write that moves the aggressor to `flt_trig_i` sets the victim to `flt_val_i`.
- R7: Kind 5 (state coupling): while the aggressor holds `flt_trig_i`, the victim reads as `flt_val_i`; otherwise its stored value is read.
- R8: Kind 6 (AND bridge): the victim and aggressor both read as the AND of their stored values.
- R9: Kind 7 (OR bridge): the victim and aggressor both read as the OR of their stored values.
- R10: Kind 8 (dynamic coupling): an access to the aggressor that is a write when `flt_trig_i` is 1, or a read when 0, sets the victim to `flt_val_i`; the aggressor access itself acts ideally.
- R11: Kind 9 (decoder aliasing): the victim address reaches the aggressor cell and the aggressor address reaches the victim cell; the stored cells are unchanged when the fault is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the array |
| en_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Cell address |
| wdata_i | input | 1 | Write data |
| rdata_o | output | 1 | Read data, registered |
| flt_kind_i | input | 4 | Fault kind, encoding as in R2 to R11 |
| flt_victim_i | input | ADDR_W | Victim cell |
| flt_aggr_i | input | ADDR_W | Aggressor cell (second cell for bridge and alias) |
| flt_val_i | input | 1 | Stuck, blocked or forced value |
| flt_trig_i | input | 1 | Edge, state or operation qualifier |

## Verification
Each fault kind is driven with the March-like pattern that exposes it: write then read the victim for stuck-at and transition faults in both polarities, toggle the aggressor through repeated, rising and falling writes to separate inversion from idempotent coupling and to show that a non-changing write is not an edge. State coupling and bridging are tried with all relevant aggressor/victim pairs so that level dependence is told apart from stored corruption. Aliasing is checked both while active and after removal, which separates an address swap from a data fault.

// File: rtl/fram_pkg.sv
package fram_pkg;
  typedef enum logic [3:0] {
    FLT_NONE       = 4'd0,
    FLT_STUCK      = 4'd1,
    FLT_TRANS      = 4'd2,
    FLT_CPL_INV    = 4'd3,
    FLT_CPL_IDEM   = 4'd4,
    FLT_CPL_STATE  = 4'd5,
    FLT_BRIDGE_AND = 4'd6,
    FLT_BRIDGE_OR  = 4'd7,
    FLT_CPL_DYN    = 4'd8,
    FLT_ALIAS      = 4'd9
  } flt_kind_e;
endpackage

// File: rtl/fram_addr_map.sv
module fram_addr_map
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  flt_kind_e         kind_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggr_i,
  output logic [ADDR_W-1:0] phys_o
);
  always_comb begin
    phys_o = addr_i;
    if (kind_i == FLT_ALIAS) begin
      if (addr_i == victim_i)    phys_o = aggr_i;
      else if (addr_i == aggr_i) phys_o = victim_i;
    end
  end
endmodule

// File: rtl/fram_next_state.sv
module fram_next_state
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEPTH-1:0]  mem_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] phys_i,
  input  logic              wdata_i,
  input  flt_kind_e         kind_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggr_i,
  input  logic              val_i,
  input  logic              trig_i,
  output logic [DEPTH-1:0]  mem_o
);
  logic wr, blocked, aggr_edge, split;

  assign wr        = en_i && we_i;
  assign split     = victim_i != aggr_i;
  // blocked transition on the victim
  assign blocked   = (kind_i == FLT_TRANS) && (phys_i == victim_i) &&
                     (mem_i[victim_i] != wdata_i) && (wdata_i == val_i);
  assign aggr_edge = wr && (phys_i == aggr_i) &&
                     (mem_i[aggr_i] != wdata_i) && (wdata_i == trig_i);

  always_comb begin
    mem_o = mem_i;
    if (wr && !blocked) mem_o[phys_i] = wdata_i;
    if (split) begin
      unique case (kind_i)
        FLT_CPL_INV:  if (aggr_edge) mem_o[victim_i] = ~mem_i[victim_i];
        FLT_CPL_IDEM: if (aggr_edge) mem_o[victim_i] = val_i;
        FLT_CPL_DYN:  if (en_i && (phys_i == aggr_i) && (we_i == trig_i))
                        mem_o[victim_i] = val_i;
        default: ;
      endcase
    end
  end

  assert_trans_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FLT_TRANS && wr && phys_i == victim_i && wdata_i == val_i &&
     mem_i[victim_i] != val_i)
    |=> mem_i[$past(victim_i)] != $past(val_i));

  assert_inv_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FLT_CPL_INV && wr && split && phys_i == aggr_i &&
     mem_i[aggr_i] != wdata_i && wdata_i == trig_i)
    |=> mem_i[$past(victim_i)] != $past(mem_i[victim_i]));

  assert_idem_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FLT_CPL_IDEM && wr && split && phys_i == aggr_i &&
     mem_i[aggr_i] != wdata_i && wdata_i == trig_i)
    |=> mem_i[$past(victim_i)] == $past(val_i));
endmodule

// File: rtl/fram_read_view.sv
module fram_read_view
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  mem_i,
  input  flt_kind_e         kind_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggr_i,
  input  logic              val_i,
  input  logic              trig_i,
  output logic [DEPTH-1:0]  view_o
);
  logic pair_and, pair_or;
  assign pair_and = mem_i[victim_i] & mem_i[aggr_i];
  assign pair_or  = mem_i[victim_i] | mem_i[aggr_i];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic is_v, is_a;
    assign is_v = ADDR_W'(i) == victim_i;
    assign is_a = ADDR_W'(i) == aggr_i;
    always_comb begin
      view_o[i] = mem_i[i];
      unique case (kind_i)
        FLT_STUCK:      if (is_v) view_o[i] = val_i;
        FLT_CPL_STATE:  if (is_v && !is_a && mem_i[aggr_i] == trig_i) view_o[i] = val_i;
        FLT_BRIDGE_AND: if (is_v || is_a) view_o[i] = pair_and;
        FLT_BRIDGE_OR:  if (is_v || is_a) view_o[i] = pair_or;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              rdata_o,
  input  logic [3:0]        flt_kind_i,
  input  logic [ADDR_W-1:0] flt_victim_i,
  input  logic [ADDR_W-1:0] flt_aggr_i,
  input  logic              flt_val_i,
  input  logic              flt_trig_i
);
  flt_kind_e         kind;
  logic [ADDR_W-1:0] phys;
  logic [DEPTH-1:0]  mem_q, mem_d, view;

  assign kind = flt_kind_e'(flt_kind_i);

  fram_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr_i(addr_i), .kind_i(kind), .victim_i(flt_victim_i),
    .aggr_i(flt_aggr_i), .phys_o(phys)
  );

  fram_next_state #(.ADDR_W(ADDR_W)) u_next (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_i(mem_q), .en_i(en_i), .we_i(we_i),
    .phys_i(phys), .wdata_i(wdata_i), .kind_i(kind), .victim_i(flt_victim_i),
    .aggr_i(flt_aggr_i), .val_i(flt_val_i), .trig_i(flt_trig_i), .mem_o(mem_d)
  );

  fram_read_view #(.ADDR_W(ADDR_W)) u_view (
    .mem_i(mem_q), .kind_i(kind), .victim_i(flt_victim_i), .aggr_i(flt_aggr_i),
    .val_i(flt_val_i), .trig_i(flt_trig_i), .view_o(view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      rdata_o <= 1'b0;
    end else begin
      mem_q <= mem_d;
      if (en_i && !we_i) rdata_o <= view[phys];
    end
  end

  assert_ideal_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == FLT_NONE && en_i && we_i) |=> mem_q[$past(addr_i)] == $past(wdata_i));

  assert_write_holds_rdata_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> $stable(rdata_o));

  assert_stuck_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == FLT_STUCK && en_i && !we_i && addr_i == flt_victim_i)
    |=> rdata_o == $past(flt_val_i));

  assert_state_cpl_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == FLT_CPL_STATE && en_i && !we_i && addr_i == flt_victim_i &&
     flt_victim_i != flt_aggr_i && mem_q[flt_aggr_i] == flt_trig_i)
    |=> rdata_o == $past(flt_val_i));
endmodule

// File: tb/fault_ram_bench.sv
module fault_ram_bench;
  localparam int AW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, we = 0, wd = 0, rdata;
  logic [AW-1:0] addr = '0, vic = '0, agg = '0;
  logic [3:0] kind = '0;
  logic fval = 0, ftrig = 0;
  int n_chk = 0, n_fail = 0;
  bit rd_seen = 0;
  bit   exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  fault_ram #(.ADDR_W(AW)) u_fault_ram (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .flt_kind_i(kind), .flt_victim_i(vic),
    .flt_aggr_i(agg), .flt_val_i(fval), .flt_trig_i(ftrig)
  );

  task automatic check(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) rd_seen <= rst_ni && en && !we;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) check(1'b1, 1'b0, "unexpected read");
    else check(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic idle();
    @(negedge clk); en = 0; we = 0;
  endtask
  task automatic wr(int a, bit d);
    @(negedge clk); en = 1; we = 1; addr = AW'(a); wd = d;
  endtask
  task automatic rd(int a, bit exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    en = 1; we = 0; addr = AW'(a);
  endtask
  task automatic cfg(int k, int v, int g, bit fv, bit ft);
    @(negedge clk); en = 0; we = 0;
    kind = 4'(k); vic = AW'(v); agg = AW'(g); fval = fv; ftrig = ft;
  endtask
  task automatic do_reset();
    @(negedge clk); en = 0; we = 0; rst_ni = 0;
    @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    check(rdata, 1'b0, "R1 rdata after reset");
    rd(7, 0, "R1 cell 7 cleared"); rd(15, 0, "R1 cell 15 cleared");
    // ideal
    wr(3, 1); wr(5, 0); wr(15, 1);
    rd(3, 1, "R2 ideal a3"); rd(5, 0, "R2 ideal a5"); rd(15, 1, "R2 ideal a15");
    rd(0, 0, "R2 ideal a0");
    wr(15, 0); idle();
    check(rdata, 1'b0, "R2 write keeps rdata");
    rd(15, 0, "R2 overwrite");
    // stuck-at
    cfg(1, 6, 0, 0, 0);
    wr(6, 1); wr(7, 1);
    rd(6, 0, "R3 stuck0 victim"); rd(7, 1, "R3 stuck0 neighbour");
    do_reset(); cfg(1, 6, 0, 1, 0);
    rd(6, 1, "R3 stuck1 victim"); wr(6, 0); rd(6, 1, "R3 stuck1 after w0");
    // transition
    do_reset(); cfg(2, 2, 0, 1, 0);
    wr(2, 1); rd(2, 0, "R4 no rise");
    do_reset(); cfg(2, 2, 0, 0, 0);
    wr(2, 1); rd(2, 1, "R4 rise ok"); wr(2, 0); rd(2, 1, "R4 no fall");
    // inversion coupling, rising
    do_reset(); cfg(3, 9, 4, 0, 1);
    wr(4, 1); rd(9, 1, "R5 rise inverts");
    wr(4, 1); rd(9, 1, "R5 no edge");
    wr(4, 0); rd(9, 1, "R5 fall ignored");
    wr(4, 1); rd(9, 0, "R5 second rise");
    // idempotent coupling, falling sets 1
    do_reset(); cfg(4, 9, 4, 1, 0);
    wr(4, 1); rd(9, 0, "R6 rise ignored");
    wr(4, 0); rd(9, 1, "R6 fall forces");
    wr(4, 1); wr(4, 0); rd(9, 1, "R6 idempotent");
    // state coupling y=1 x=0
    do_reset(); cfg(5, 11, 10, 0, 1);
    wr(11, 1); rd(11, 1, "R7 aggr 0");
    wr(10, 1); rd(11, 0, "R7 aggr 1");
    wr(10, 0); rd(11, 1, "R7 released");
    // AND bridge
    do_reset(); cfg(6, 12, 13, 0, 0);
    wr(12, 1); rd(12, 0, "R8 10 a12"); rd(13, 0, "R8 10 a13");
    wr(13, 1); rd(12, 1, "R8 11 a12"); rd(13, 1, "R8 11 a13");
    // OR bridge
    do_reset(); cfg(7, 12, 13, 0, 0);
    rd(13, 0, "R9 00");
    wr(12, 1); rd(13, 1, "R9 10 a13"); rd(12, 1, "R9 10 a12");
    wr(12, 0); rd(13, 0, "R9 back 00");
    // dynamic coupling on read
    do_reset(); cfg(8, 8, 1, 1, 0);
    rd(1, 0, "R10 aggr read"); rd(8, 1, "R10 read forces");
    // dynamic coupling on write
    do_reset(); cfg(8, 8, 1, 0, 1);
    wr(8, 1); rd(8, 1, "R10 victim set");
    rd(1, 0, "R10 read no effect"); rd(8, 1, "R10 still set");
    wr(1, 1); rd(8, 0, "R10 write forces"); rd(1, 1, "R10 aggr written");
    // aliasing
    do_reset(); cfg(9, 5, 14, 0, 0);
    wr(5, 1); rd(5, 1, "R11 alias a5"); rd(14, 0, "R11 alias a14");
    cfg(0, 0, 0, 0, 0);
    rd(14, 1, "R11 removed a14"); rd(5, 0, "R11 removed a5");
    idle(); idle(); idle();
    if (exp_q.size() != 0) check(1'b0, 1'b1, "R2 pending reads");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule